// File: doc/BRIEF.md
# Main Clock Frequency Meter

This block estimates how fast the main oscillator runs by counting its cycles over a gate window that the slow clock times. Software or a supervisor pulses the trigger, synchronous to the slow clock. The block then holds its gate closed for a short settling stretch and opens it for sixteen slow-clock periods. The main-clock domain counts every main-clock edge it sees while its synchronized copy of the gate is high. When the gate closes, the main domain sends a toggle back across the domains. The slow domain then takes the frozen count and raises the ready flag.

A result of zero means the main oscillator is not running. Supervising logic can then move the system back to the internal RC source. If no acknowledge arrives within a bounded number of slow cycles after the gate closes, the block reports zero and sets ready anyway, so a dead oscillator never leaves the reader waiting.

The count and ready flag are plain status outputs in the slow-clock domain. They are meant for a simple read port, with no handshake. The count is valid only while ready is high. It stays unchanged until the next trigger.

Top module: `main_clk_meter`

## Requirements
- R1: After reset, `freq_ready` is 0 and `freq_count` is 0, and both stay so until a trigger arrives.
- R2: The gate is open for exactly 16 slow-clock periods, so the reported count equals 16 x Tslow / Tmain to within one main-clock cycle.
- R3: Once `freq_ready` is 1, it remains 1 and `freq_count` holds its value until the next trigger.
- R4: A trigger sampled high on a slow-clock edge drives `freq_ready` to 0 at that same edge.
- R5: If the main clock does not run, `freq_ready` still rises within 40 slow-clock periods of the trigger, and `freq_count` reads 0. A later measurement with the clock running reports a normal count again.
- R6: The 16-bit count saturates at 65535 and does not wrap.
- R7: A trigger that arrives while a window is open aborts it and starts a fresh window. The result then reflects one complete window measured from the newest trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_main | input | 1 | Main clock being measured |
| clk_slow | input | 1 | Slow reference clock; times the window and drives the status outputs |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| start | input | 1 | Start/restart trigger, synchronous to clk_slow |
| freq_count | output | CNT_W (16) | Main-clock cycles counted in the last window; 0 means no oscillation |
| freq_ready | output | 1 | High when freq_count holds a completed result |

## Verification
A wrong gate length or a mis-sequenced window state would show up at the next ready assertion. It appears as a count far from the expected period ratio, because each extra or missing slow period shifts the result by about Tslow/Tmain. A broken acknowledge or timeout path would show up as `freq_ready` failing to rise within its 40-slow-cycle bound, or as a nonzero count with the main clock stopped. Wrapping instead of saturating would show up as a small count after a very long window. Any failure to clear ready is visible one slow edge after the trigger.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_OPEN = 2'd2,
    ST_WAIT = 2'd3
  } gate_st_t;
endpackage

// File: rtl/mcm_sync.sv
module mcm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mcm_counter.sv
// Main-clock domain: counts while the synchronized gate is high and
// flips an acknowledge toggle once the gate has closed.
module mcm_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_main,
  input  logic             rst_n,
  input  logic             gate_slow,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_tgl_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic gate_s, gate_d;
  logic [CNT_W-1:0] cnt;
  logic tgl;

  mcm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk_main), .rst_n(rst_n), .d(gate_slow), .q(gate_s)
  );

  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n) begin
      gate_d <= 1'b0;
      cnt    <= '0;
      tgl    <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (gate_s && !gate_d)
        cnt <= CNT_W'(1);
      else if (gate_s && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
      if (!gate_s && gate_d)
        tgl <= ~tgl;
    end
  end

  assign cnt_o      = cnt;
  assign done_tgl_o = tgl;

  // R6
  sat_hold_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
    (gate_s && gate_d && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R2
  closed_frozen_chk: assert property (@(posedge clk_main) disable iff (!rst_n)
    (gate_d && !gate_s) |=> $stable(cnt));
endmodule

// File: rtl/mcm_gate_ctl.sv
// Slow-clock domain: window sequencing, timeout and result capture.
module mcm_gate_ctl
  import mcm_pkg::*;
#(
  parameter int WIN         = 16,
  parameter int PREP        = 6,
  parameter int TMO         = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ack_tgl,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             gate_o,
  output logic             ready_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int TMR_MAX = (WIN > PREP) ? ((WIN > TMO) ? WIN : TMO)
                                        : ((PREP > TMO) ? PREP : TMO);
  localparam int TMR_W = $clog2(TMR_MAX + 1);

  gate_st_t st;
  logic [TMR_W-1:0] tmr;
  logic ack_s, base;

  mcm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_slow), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tmr     <= '0;
      base    <= 1'b0;
      gate_o  <= 1'b0;
      ready_o <= 1'b0;
      count_o <= '0;
    end else if (start) begin
      st      <= ST_PREP;
      tmr     <= '0;
      gate_o  <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_PREP: begin
          if (tmr == TMR_W'(PREP - 1)) begin
            base   <= ack_s;
            gate_o <= 1'b1;
            tmr    <= '0;
            st     <= ST_OPEN;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_OPEN: begin
          if (tmr == TMR_W'(WIN - 1)) begin
            gate_o <= 1'b0;
            tmr    <= '0;
            st     <= ST_WAIT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WAIT: begin
          if (ack_s != base) begin
            count_o <= cnt_in;
            ready_o <= 1'b1;
            st      <= ST_IDLE;
          end else if (tmr == TMR_W'(TMO - 1)) begin
            count_o <= '0;
            ready_o <= 1'b1;
            st      <= ST_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  gate_close_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (st == ST_OPEN && tmr == TMR_W'(WIN - 1) && !start) |=> !gate_o);

  // R2
  gate_open_src_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
    $rose(gate_o) |-> ($past(st) == ST_PREP));

  // R3
  ready_hold_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (ready_o && !start) |=> (ready_o && $stable(count_o)));

  // R4
  start_clr_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
    start |=> !ready_o);

  // R5
  timeout_zero_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (st == ST_WAIT && ack_s == base && tmr == TMR_W'(TMO - 1) && !start)
      |=> (ready_o && count_o == '0));
endmodule

// File: rtl/main_clk_meter.sv
module main_clk_meter #(
  parameter int WIN_CYCLES  = 16,
  parameter int CNT_W       = 16,
  parameter int PREP_CYCLES = 6,
  parameter int TMO_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_main,
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] freq_count,
  output logic             freq_ready
);
  logic             gate;
  logic             ack_tgl;
  logic [CNT_W-1:0] main_cnt;

  mcm_gate_ctl #(
    .WIN(WIN_CYCLES), .PREP(PREP_CYCLES), .TMO(TMO_CYCLES),
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctl (
    .clk_slow(clk_slow), .rst_n(rst_n), .start(start),
    .ack_tgl(ack_tgl), .cnt_in(main_cnt),
    .gate_o(gate), .ready_o(freq_ready), .count_o(freq_count)
  );

  mcm_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
    .clk_main(clk_main), .rst_n(rst_n), .gate_slow(gate),
    .cnt_o(main_cnt), .done_tgl_o(ack_tgl)
  );
endmodule

// File: tb/main_clk_meter_test.sv
`timescale 1ns/1ps
module main_clk_meter_test;
  logic clk_main = 1'b0, clk_slow = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic main_en = 1'b1;
  logic [15:0] freq_count;
  logic freq_ready;
  realtime slow_half = 20.5ns;
  int checks = 0, errors = 0;

  // slow half-periods in ps; expected count = 32*half/4000 (250 MHz main)
  localparam int VEC_N = 4;
  localparam int VEC_HALF [VEC_N] = '{20500, 50500, 100300, 33700};

  main_clk_meter uut (
    .clk_main(clk_main), .clk_slow(clk_slow), .rst_n(rst_n),
    .start(start), .freq_count(freq_count), .freq_ready(freq_ready)
  );

  always #2ns if (main_en) clk_main = ~clk_main; else clk_main = 1'b0;
  always #(slow_half) clk_slow = ~clk_slow;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic trig();
    @(negedge clk_slow) start = 1'b1;
    @(negedge clk_slow) start = 1'b0;
  endtask

  task automatic wait_ready(input int lim, output bit got);
    got = 1'b0;
    for (int i = 0; i < lim && !got; i++) begin
      @(negedge clk_slow);
      if (freq_ready) got = 1'b1;
    end
  endtask

  function automatic bit near(input int act, input int exp);
    return (act >= exp - 1) && (act <= exp + 1);
  endfunction

  initial begin
    #(780us);
    checks++; errors++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    int exp, held;
    repeat (4) @(negedge clk_slow);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_slow);
    // R1 reset state, no trigger yet
    chk(freq_ready == 1'b0, "R1 ready", freq_ready, 0);
    chk(freq_count == 16'd0, "R1 count", freq_count, 0);

    // R2 table of slow periods
    for (int v = 0; v < VEC_N; v++) begin
      slow_half = VEC_HALF[v] * 1ps;
      repeat (2) @(negedge clk_slow);
      exp = (32 * VEC_HALF[v]) / 4000;
      trig();
      chk(freq_ready == 1'b0, "R4 cleared", freq_ready, 0);
      wait_ready(40, got);
      chk(got, "R2 ready", got, 1);
      chk(near(freq_count, exp), "R2 count", freq_count, exp);
    end

    // R3 hold while ready
    held = freq_count;
    repeat (10) @(negedge clk_slow);
    chk(freq_ready == 1'b1, "R3 ready held", freq_ready, 1);
    chk(freq_count == held, "R3 count held", freq_count, held);

    // R7 restart inside an open window
    slow_half = 20.5ns;
    repeat (2) @(negedge clk_slow);
    trig();
    repeat (12) @(negedge clk_slow);
    trig();
    chk(freq_ready == 1'b0, "R7 cleared", freq_ready, 0);
    wait_ready(40, got);
    chk(got, "R7 ready", got, 1);
    chk(near(freq_count, 164), "R7 count", freq_count, 164);

    // R5 dead main clock
    main_en = 1'b0;
    trig();
    wait_ready(40, got);
    chk(got, "R5 ready", got, 1);
    chk(freq_count == 16'd0, "R5 zero", freq_count, 0);
    main_en = 1'b1;
    trig();
    wait_ready(40, got);
    chk(got && near(freq_count, 164), "R5 recovery", freq_count, 164);

    // R6 saturation: window of 320 us = 80000 main cycles
    slow_half = 10us;
    repeat (2) @(negedge clk_slow);
    trig();
    wait_ready(40, got);
    chk(got, "R6 ready", got, 1);
    chk(freq_count == 16'hFFFF, "R6 saturate", freq_count, 65535);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule